// File: doc/BRIEF.md
# Local-Bus DMA Write Sequencer

This block is a single-channel DMA engine that masters a simple local bus. Software sets a start address, a byte count and a mode word through a small register-style port. A start command then makes the block pull 32-bit words from an input stream and write them out as local bus cycles. Each cycle has an address phase and one or more data beats. The mode word selects:

- the port width (8, 16 or 32 bits), with wide words split into narrow beats;
- the idle clocks between beats;
- whether the ready input is honoured;
- single cycles or bursts, and how a burst is cut;
- a fixed or stepping address;
- demand-paced transfer with request and acknowledge pins;
- how an end-of-transfer (EOT) request stops the channel;
- whether a done interrupt is raised.

Configuration port: a write with `cfg_sel` equal to 0 loads the start address, 1 loads the byte count, 2 loads the mode word, and 3 issues a start. Mode word bit positions:

| Bits | Meaning |
|------|---------|
| [1:0] | Port width |
| [5:2] | Idle wait count |
| 6 | Ready enable |
| 7 | Burst-terminate enable |
| 8 | Burst enable |
| 9 | Fixed address |
| 10 | Demand mode |
| 11 | EOT enable |
| 12 | EOT stop-now |
| 13 | Done interrupt enable |

Stream rules: `s_data` must stay stable while `s_valid` is high and `s_ready` is low. A word is taken on the cycle `s_valid` and `s_ready` are both high. When `s_valid` is low, the block holds its current beat and drives no data strobe.

Top module: `lbus_dma_seq`

## Requirements
- R1: Width code 00 gives byte beats, 01 gives 16-bit beats, and 10 or 11 give 32-bit beats. On a narrow port, each stream word leaves as 4 or 2 beats. Each beat carries the next lane of the word, shifted down to bit 0 of `lb_wdata`.
- R2: When the idle wait count (mode bits [5:2]) is N, consecutive beats inside one burst are N+1 clocks apart.
- R3: With mode bit 6 set, a beat completes only in a cycle where `lb_ready` is high. With bit 6 clear, `lb_ready` is ignored.
- R4: With mode bit 7 clear, a burst never carries more than 16 bytes, so a new address phase follows every 16 bytes. With bit 7 set, `lb_bterm` high during a completing beat ends the burst, and the next beat gets a new address phase.
- R5: With mode bit 8 clear, every beat has its own address phase and carries `lb_blast`.
- R6: With mode bit 9 set, address bits [31:2] hold their start value for the whole transfer, and only the byte-lane bits step. With bit 9 clear, the address rises by the beat width after every beat.
- R7: With mode bit 10 set, no address phase is issued while `dreq_n` is high. Each stream word forms its own burst, ending with `lb_blast`. `dack_n` is low during every data beat.
- R8: With mode bits 11 and 12 set, an EOT seen on `eot_n` while busy ends the transfer after the data beat in progress.
- R9: With mode bit 11 set and bit 12 clear, an EOT lets the beat in progress complete. At most one further beat follows, and that beat carries `lb_blast`; then the transfer ends.
- R10: `irq_done` rises when a transfer ends only if mode bit 13 is set. It clears on the next accepted start.
- R11: The count drops by the beat width on every beat, and its two low bits are ignored. The beat that brings it to zero carries `lb_blast` and ends the transfer. A start with a zero count ends at once, with no bus cycles.
- R12: A start issued while `busy` is high is ignored. The running transfer keeps its latched address, count and mode.
- R13: `s_ready` is high only on the final beat of each word, and `lb_dval` is high only while `s_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 address, 1 count, 2 mode, 3 start |
| cfg_wdata | input | 32 | Configuration write data |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 32 | Stream word |
| s_ready | output | 1 | Stream word taken |
| lb_ads | output | 1 | Address phase strobe |
| lb_addr | output | 32 | Byte address of the current beat |
| lb_dval | output | 1 | Data beat strobe |
| lb_wdata | output | 32 | Beat write data, low-aligned |
| lb_ready | input | 1 | Target ready |
| lb_bterm | input | 1 | Target asks to end the burst |
| lb_blast | output | 1 | Last beat of the burst |
| dreq_n | input | 1 | Demand request, active low, asynchronous |
| dack_n | output | 1 | Demand acknowledge, active low |
| eot_n | input | 1 | End-of-transfer request, active low, asynchronous |
| busy | output | 1 | Transfer in progress |
| irq_done | output | 1 | Done interrupt flag |

## Verification
Two functions can fall in the same cycle: an EOT request and a beat that is already on the bus. The same holds for a start command and a transfer in progress. The bench stalls a beat by holding `lb_ready` low, asserts `eot_n` during the stall, and then releases ready. It judges the outcome by the number of beats and where `lb_blast` falls, once for each of the two stop styles. It also writes new configuration and a second start while a stalled transfer is running. It then checks that the beats and the address phase follow the first setup.

// File: rtl/lbus_dma_pkg.sv
package lbus_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_WAIT
  } dma_state_e;

  // Mode word layout, bit 13 down to bit 0
  typedef struct packed {
    logic       done_irq_en;
    logic       eot_stop_now;
    logic       eot_en;
    logic       demand;
    logic       fixed_addr;
    logic       burst_en;
    logic       bterm_en;
    logic       rdy_en;
    logic [3:0] wait_st;
    logic [1:0] width;
  } dma_mode_t;

  function automatic logic [2:0] beat_bytes(input logic [1:0] w);
    case (w)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/lbus_dma_sync.sv
module lbus_dma_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_n,
  output logic [WIDTH-1:0] sync_act
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[s] <= '1;
          else        pipe[s] <= async_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[s] <= '1;
          else        pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign sync_act = ~pipe[STAGES-1];
endmodule

// File: rtl/lbus_dma_cfg.sv
module lbus_dma_cfg
  import lbus_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CNT_W-1:0]  byte_cnt,
  output dma_mode_t         mode,
  output logic              start_req
);
  localparam int MODE_W = $bits(dma_mode_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_addr <= '0;
      byte_cnt   <= '0;
      mode       <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    start_addr <= cfg_wdata[ADDR_W-1:0];
        2'd1:    byte_cnt   <= cfg_wdata[CNT_W-1:0];
        2'd2:    mode       <= dma_mode_t'(cfg_wdata[MODE_W-1:0]);
        default: ;
      endcase
    end
  end

  assign start_req = cfg_we && (cfg_sel == 2'd3);
endmodule

// File: rtl/lbus_dma_seq.sv
module lbus_dma_seq
  import lbus_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int BURST_WORDS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              s_valid,
  input  logic [31:0]       s_data,
  output logic              s_ready,
  output logic              lb_ads,
  output logic [ADDR_W-1:0] lb_addr,
  output logic              lb_dval,
  output logic [31:0]       lb_wdata,
  input  logic              lb_ready,
  input  logic              lb_bterm,
  output logic              lb_blast,
  input  logic              dreq_n,
  output logic              dack_n,
  input  logic              eot_n,
  output logic              busy,
  output logic              irq_done
);
  localparam int CAP_B = BURST_WORDS * 4;
  localparam int BB_W  = $clog2(CAP_B + 1) + 1;

  logic [ADDR_W-1:0] cfg_addr;
  logic [CNT_W-1:0]  cfg_cnt;
  dma_mode_t         cfg_mode;
  logic              start_req;

  lbus_dma_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start_addr(cfg_addr), .byte_cnt(cfg_cnt),
    .mode(cfg_mode), .start_req(start_req)
  );

  logic [1:0] hs_act;
  lbus_dma_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_n({eot_n, dreq_n}), .sync_act(hs_act)
  );
  logic req_act, eot_act;
  assign req_act = hs_act[0];
  assign eot_act = hs_act[1];

  dma_state_e        state;
  dma_mode_t         mode_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        lane;
  logic [BB_W-1:0]   bbytes;
  logic [3:0]        wcnt;
  logic              eot_p, eot_fin, irq_q;

  logic [2:0] bw;
  logic       beat_go, word_last, cnt_last, cap_hit, bterm_hit, finish;
  logic [CNT_W-1:0] start_cnt;

  assign bw        = beat_bytes(mode_q.width);
  assign start_cnt = cfg_cnt & ~CNT_W'(3);
  assign beat_go   = (state == ST_DATA) && s_valid && (!mode_q.rdy_en || lb_ready);
  assign word_last = ({1'b0, lane} + bw) >= 3'd4;
  assign cnt_last  = cnt == CNT_W'(bw);
  assign cap_hit   = !mode_q.bterm_en && ((int'(bbytes) + int'(bw)) >= CAP_B);
  assign bterm_hit = mode_q.bterm_en && lb_bterm;

  assign lb_blast  = (state == ST_DATA) &&
                     (!mode_q.burst_en || cnt_last || cap_hit ||
                      (mode_q.demand && word_last) || eot_fin);
  assign finish    = cnt_last || eot_fin || (eot_p && (mode_q.eot_stop_now || lb_blast));

  assign lb_ads    = (state == ST_ADDR) && (!mode_q.demand || req_act);
  assign lb_dval   = (state == ST_DATA) && s_valid;
  assign lb_addr   = cur_addr;
  assign lb_wdata  = s_data >> {lane, 3'b000};
  assign s_ready   = beat_go && word_last;
  assign dack_n    = !(mode_q.demand && (state == ST_DATA));
  assign busy      = state != ST_IDLE;
  assign irq_done  = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_q   <= '0;
      cur_addr <= '0;
      cnt      <= '0;
      lane     <= '0;
      bbytes   <= '0;
      wcnt     <= '0;
      eot_p    <= 1'b0;
      eot_fin  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (busy && mode_q.eot_en && eot_act) eot_p <= 1'b1;
      case (state)
        ST_IDLE: if (start_req) begin
          mode_q   <= cfg_mode;
          cur_addr <= cfg_addr;
          cnt      <= start_cnt;
          lane     <= '0;
          bbytes   <= '0;
          eot_p    <= 1'b0;
          eot_fin  <= 1'b0;
          if (start_cnt == '0) begin
            irq_q <= cfg_mode.done_irq_en;
          end else begin
            irq_q <= 1'b0;
            state <= ST_ADDR;
          end
        end
        ST_ADDR: if (lb_ads) begin
          bbytes <= '0;
          state  <= ST_DATA;
        end
        ST_DATA: if (beat_go) begin
          cnt    <= cnt - CNT_W'(bw);
          lane   <= lane + bw[1:0];
          bbytes <= bbytes + BB_W'(bw);
          cur_addr <= mode_q.fixed_addr ?
                      {cur_addr[ADDR_W-1:2], cur_addr[1:0] + bw[1:0]} :
                      cur_addr + ADDR_W'(bw);
          if (finish) begin
            state <= ST_IDLE;
            irq_q <= mode_q.done_irq_en;
          end else begin
            if (eot_p && !mode_q.eot_stop_now) eot_fin <= 1'b1;
            if (lb_blast || bterm_hit) state <= ST_ADDR;
            else if (mode_q.wait_st != 4'd0) begin
              state <= ST_WAIT;
              wcnt  <= mode_q.wait_st;
            end
          end
        end
        ST_WAIT: begin
          if (wcnt == 4'd1) state <= ST_DATA;
          else              wcnt  <= wcnt - 4'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker state: bytes moved since the last address phase
  logic [15:0] chk_bytes;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       chk_bytes <= '0;
    else if (lb_ads)  chk_bytes <= '0;
    else if (beat_go) chk_bytes <= chk_bytes + 16'(bw);

  a_r4_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_go && !mode_q.bterm_en) |-> ((chk_bytes + 16'(bw)) <= 16'(CAP_B)));

  a_r2_wait_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_go && mode_q.wait_st != 4'd0) |=> !lb_dval);

  a_r3_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.rdy_en && s_ready) |-> lb_ready);

  a_r6_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q.fixed_addr && $past(busy)) |->
      (lb_addr[ADDR_W-1:2] == $past(lb_addr[ADDR_W-1:2])));

  a_r7_dack_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_go && mode_q.demand) |-> !dack_n);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> mode_q.done_irq_en);

  a_r13_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (s_valid && lb_dval));
endmodule

// File: tb/lbus_dma_seq_bench.sv
module lbus_dma_seq_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        s_valid = 1'b1;
  logic [31:0] s_data;
  logic        s_ready;
  logic        lb_ads, lb_dval, lb_blast, dack_n, busy, irq_done;
  logic [31:0] lb_addr, lb_wdata;
  logic        lb_ready = 1'b1;
  logic        lb_bterm = 1'b0;
  logic        dreq_n = 1'b1;
  logic        eot_n = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbus_dma_seq u_lbus_dma_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .lb_ads(lb_ads), .lb_addr(lb_addr), .lb_dval(lb_dval), .lb_wdata(lb_wdata),
    .lb_ready(lb_ready), .lb_bterm(lb_bterm), .lb_blast(lb_blast),
    .dreq_n(dreq_n), .dack_n(dack_n), .eot_n(eot_n), .busy(busy), .irq_done(irq_done)
  );

  int widx = 0;
  assign s_data = 32'hA500_0000 + widx;
  always @(posedge clk) if (s_ready) widx <= widx + 1;

  int checks = 0, errors = 0, cyc = 0;
  int n_ads = 0, n_b = 0, w0 = 0;
  logic tb_rdy = 1'b0;
  logic [31:0] ads_addr [64];
  logic [31:0] b_data [64];
  logic        b_blast [64];
  logic        b_dack [64];
  int          b_cyc [64];

  always @(negedge clk) begin
    cyc++;
    if (lb_ads && n_ads < 64) begin ads_addr[n_ads] = lb_addr; n_ads++; end
    if (lb_dval && (!tb_rdy || lb_ready) && n_b < 64) begin
      b_data[n_b] = lb_wdata; b_blast[n_b] = lb_blast;
      b_dack[n_b] = dack_n;   b_cyc[n_b] = cyc; n_b++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic start_xfer(input logic [31:0] a, input logic [31:0] c, input logic [31:0] m);
    cfg_write(2'd0, a); cfg_write(2'd1, c); cfg_write(2'd2, m);
    @(posedge clk); n_ads = 0; n_b = 0; w0 = widx;
    cfg_write(2'd3, 32'd0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    chk("R11 transfer ends", {31'd0, busy}, 32'd0);
  endtask

  function automatic logic [7:0] wbyte(input int w, input int k);
    logic [31:0] v = 32'hA500_0000 + w;
    return v[8*k +: 8];
  endfunction

  task automatic t_reset();
    chk("R10 reset irq", {31'd0, irq_done}, 0);
    chk("R11 reset busy", {31'd0, busy}, 0);
    chk("R7 reset dack", {31'd0, dack_n}, 1);
    chk("R13 reset strobes", {30'd0, lb_ads, lb_dval}, 0);
  endtask

  task automatic t_burst32();
    start_xfer(32'h1000, 12, 32'h2182);
    wait_idle();
    chk("R11 beats", n_b, 3);
    chk("R11 one address phase", n_ads, 1);
    chk("R6 start address", ads_addr[0], 32'h1000);
    chk("R11 blast only final", {29'd0, b_blast[0], b_blast[1], b_blast[2]}, 1);
    chk("R13 data order", b_data[2], 32'hA500_0000 + w0 + 2);
    chk("R10 irq raised", {31'd0, irq_done}, 1);
  endtask

  task automatic t_cap();
    start_xfer(32'h2000, 32, 32'h2102);
    wait_idle();
    chk("R4 cap address phases", n_ads, 2);
    chk("R4 second burst address", ads_addr[1], 32'h2010);
    chk("R4 blast at cap", {30'd0, b_blast[3], b_blast[7]}, 3);
  endtask

  task automatic t_bterm();
    lb_bterm = 1'b1;
    start_xfer(32'h2100, 16, 32'h2182);
    wait_idle();
    lb_bterm = 1'b0;
    chk("R4 bterm address phases", n_ads, 4);
    chk("R4 bterm last address", ads_addr[3], 32'h210C);
  endtask

  task automatic t_narrow8();
    int bl = 0;
    start_xfer(32'h3000, 8, 32'h2000);
    wait_idle();
    for (int i = 0; i < 8; i++) bl += b_blast[i];
    chk("R5 address per beat", n_ads, 8);
    chk("R5 blast per beat", bl, 8);
    chk("R6 byte address step", ads_addr[7], 32'h3007);
    chk("R1 byte lane 1", {24'd0, b_data[1][7:0]}, {24'd0, wbyte(w0, 1)});
    chk("R1 byte lane 5", {24'd0, b_data[5][7:0]}, {24'd0, wbyte(w0 + 1, 1)});
    chk("R13 words taken", widx - w0, 2);
  endtask

  task automatic t_fixed16();
    start_xfer(32'h4000, 8, 32'h2201);
    wait_idle();
    chk("R6 fixed beats", n_ads, 4);
    chk("R6 fixed addr 2", ads_addr[2], 32'h4000);
    chk("R6 fixed addr 3", ads_addr[3], 32'h4002);
  endtask

  task automatic t_wait();
    start_xfer(32'h4100, 8, 32'h218E);
    wait_idle();
    chk("R2 beat spacing", b_cyc[1] - b_cyc[0], 4);
  endtask

  task automatic t_rdy_ignored();
    lb_ready = 1'b0;
    start_xfer(32'h4200, 8, 32'h2182);
    wait_idle();
    lb_ready = 1'b1;
    chk("R3 ready ignored", n_b, 2);
  endtask

  task automatic t_rdy_honoured();
    tb_rdy = 1'b1; lb_ready = 1'b0;
    start_xfer(32'h4300, 8, 32'h21C2);
    repeat (20) @(negedge clk);
    chk("R3 stalled no beat", n_b, 0);
    chk("R3 still busy", {31'd0, busy}, 1);
    lb_ready = 1'b1;
    wait_idle();
    chk("R3 beats after ready", n_b, 2);
    tb_rdy = 1'b0;
  endtask

  task automatic t_demand();
    int dk = 0;
    start_xfer(32'h5000, 8, 32'h2581);
    repeat (20) @(negedge clk);
    chk("R7 no address without request", n_ads, 0);
    dreq_n = 1'b0;
    wait_idle();
    dreq_n = 1'b1;
    for (int i = 0; i < 4; i++) dk += b_dack[i];
    chk("R7 narrow beats", n_b, 4);
    chk("R7 burst per word", n_ads, 2);
    chk("R7 dack low on beats", dk, 0);
    chk("R7 blast at word end", {31'd0, b_blast[1]}, 1);
  endtask

  task automatic t_eot(input logic stop_now);
    tb_rdy = 1'b1; lb_ready = 1'b0;
    start_xfer(32'h5100, 64, stop_now ? 32'h39C2 : 32'h29C2);
    repeat (8) @(negedge clk);
    eot_n = 1'b0;
    repeat (6) @(negedge clk);
    eot_n = 1'b1;
    lb_ready = 1'b1;
    wait_idle();
    tb_rdy = 1'b0;
    if (stop_now) chk("R8 stop after current beat", n_b, 1);
    else begin
      chk("R9 one extra beat", n_b, 2);
      chk("R9 extra beat has blast", {30'd0, b_blast[0], b_blast[1]}, 1);
    end
  endtask

  task automatic t_restart_ignored();
    tb_rdy = 1'b1; lb_ready = 1'b0;
    start_xfer(32'h6000, 16, 32'h21C2);
    repeat (4) @(negedge clk);
    cfg_write(2'd0, 32'h7000); cfg_write(2'd1, 4); cfg_write(2'd3, 0);
    repeat (4) @(negedge clk);
    lb_ready = 1'b1;
    wait_idle();
    tb_rdy = 1'b0;
    chk("R12 original count kept", n_b, 4);
    chk("R12 original address kept", ads_addr[0], 32'h6000);
    chk("R12 single address phase", n_ads, 1);
  endtask

  task automatic t_irq_off();
    start_xfer(32'h8000, 8, 32'h0182);
    wait_idle();
    @(negedge clk);
    chk("R10 irq masked", {31'd0, irq_done}, 0);
    chk("R10 transfer still ran", n_b, 2);
  endtask

  task automatic t_zero();
    start_xfer(32'h9000, 3, 32'h2182);
    chk("R11 zero count not busy", {31'd0, busy}, 0);
    chk("R11 zero count irq", {31'd0, irq_done}, 1);
    repeat (4) @(negedge clk);
    chk("R11 zero count no cycles", n_ads + n_b, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_burst32();
    t_cap();
    t_bterm();
    t_narrow8();
    t_fixed16();
    t_wait();
    t_rdy_ignored();
    t_rdy_honoured();
    t_demand();
    t_eot(1'b1);
    t_eot(1'b0);
    t_restart_ignored();
    t_irq_off();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule